// File: doc/BRIEF.md
# Accumulator with Extend Bit and Arithmetic-Logic Stage

This block holds the working accumulator of a small word-oriented processor together with its one-bit extend flag, and the combinational arithmetic-logic stage that computes the accumulator's next value. The sequencer raises one operation strobe per cycle. Eleven strobes exist. Seven are data operations: bitwise AND with the data word, addition of the data word, loading the data word, taking in a byte from the character input, inverting every bit, and rotating right or left. The other four are increment, clear, clear-extend and invert-extend.

The rotates pass through the extend bit, so the accumulator and the extend bit form one 17-bit ring. Addition places its carry-out in the extend bit. A byte input replaces only the low eight bits of the accumulator. The block also produces three status lines for the skip logic: accumulator zero, accumulator sign and extend zero. It exposes its three load controls for the accumulator: a load strobe for all data operations, an increment strobe and a clear strobe. When several operations are requested at once, clear wins over increment, and increment wins over load.

Top module: `acc_ext_unit`

## Requirements
- R1: While `rst_n` is low, `acc_o` is 0 and `ext_o` is 0.
- R2: `op_and` sets the accumulator to its bitwise AND with `dr_i` on the next clock edge and leaves `ext_o` unchanged.
- R3: `op_add` sets `{ext_o, acc_o}` to the 17-bit sum of the accumulator and `dr_i`, so the carry-out lands in `ext_o`.
- R4: `op_ldr` copies `dr_i` into the accumulator and leaves `ext_o` unchanged.
- R5: `op_inp` replaces `acc_o[7:0]` with `inp_i` and keeps `acc_o[15:8]` and `ext_o` unchanged.
- R6: `op_cma` inverts every accumulator bit and leaves `ext_o` unchanged.
- R7: `op_cir` rotates right through the extend bit: the new `acc_o[15]` is the old `ext_o`, the new `acc_o[14:0]` is the old `acc_o[15:1]`, and the new `ext_o` is the old `acc_o[0]`.
- R8: `op_cil` rotates left through the extend bit: the new `acc_o[0]` is the old `ext_o`, the new `acc_o[15:1]` is the old `acc_o[14:0]`, and the new `ext_o` is the old `acc_o[15]`.
- R9: `op_inc` adds 1 to the accumulator modulo 2^16, so FFFF becomes 0000, and leaves `ext_o` unchanged.
- R10: `op_cla` sets the accumulator to 0. `op_cle` sets `ext_o` to 0. `op_cme` inverts `ext_o`. The two extend operations leave the accumulator unchanged.
- R11: With no strobe raised, `acc_o` and `ext_o` hold their values whatever `dr_i` and `inp_i` carry.
- R12: `acc_zero_o` is 1 exactly when `acc_o` is 0. `acc_neg_o` equals `acc_o[15]`. `ext_zero_o` is 1 exactly when `ext_o` is 0.
- R13: `ld_o` is 1 when any of the seven data strobes is raised, `inr_o` follows `op_inc`, and `clr_o` follows `op_cla`, all combinationally. When several are raised, the accumulator takes the clear result first, then the increment result, then the load result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_and | input | 1 | AND `dr_i` into accumulator |
| op_add | input | 1 | Add `dr_i`, carry-out to extend |
| op_ldr | input | 1 | Load `dr_i` |
| op_inp | input | 1 | Load low byte from `inp_i` |
| op_cma | input | 1 | Invert accumulator |
| op_cir | input | 1 | Rotate right through extend |
| op_cil | input | 1 | Rotate left through extend |
| op_inc | input | 1 | Increment accumulator |
| op_cla | input | 1 | Clear accumulator |
| op_cle | input | 1 | Clear extend bit |
| op_cme | input | 1 | Invert extend bit |
| dr_i | input | 16 | Data operand word |
| inp_i | input | 8 | Character input byte |
| acc_o | output | 16 | Accumulator |
| ext_o | output | 1 | Extend bit |
| acc_zero_o | output | 1 | Accumulator equals zero |
| acc_neg_o | output | 1 | Accumulator sign bit |
| ext_zero_o | output | 1 | Extend bit is zero |
| ld_o | output | 1 | Accumulator load control |
| inr_o | output | 1 | Accumulator increment control |
| clr_o | output | 1 | Accumulator clear control |

## Verification
The bench chains operations so that each one starts from the state the previous one left. A rotate that skipped the extend bit, or an addition that dropped its carry, therefore shows up as a wrong value in every later step. It pairs the two rotates with a set top bit and a set extend bit, because a plain shift would lose the bit that wraps around. An increment from FFFF checks that the carry leaves the extend bit alone. A byte input checks that the upper byte is kept rather than cleared. Simultaneous strobes check the clear-over-increment-over-load order, and an addition of two negative words checks that a zero accumulator and a set extend bit are flagged together.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        SEL_AND = 3'd0,
        SEL_ADD = 3'd1,
        SEL_DR  = 3'd2,
        SEL_INP = 3'd3,
        SEL_COM = 3'd4,
        SEL_SHR = 3'd5,
        SEL_SHL = 3'd6
    } data_sel_e;

endpackage

// File: rtl/acc_gate.sv
module acc_gate
    import acc_pkg::*;
(
    input  logic      op_and,
    input  logic      op_add,
    input  logic      op_ldr,
    input  logic      op_inp,
    input  logic      op_cma,
    input  logic      op_cir,
    input  logic      op_cil,
    input  logic      op_inc,
    input  logic      op_cla,
    input  logic      op_cle,
    input  logic      op_cme,
    output logic      ld,
    output logic      inr,
    output logic      clr,
    output data_sel_e sel,
    output logic      e_clr,
    output logic      e_cpl
);

    always_comb begin
        ld    = op_and | op_add | op_ldr | op_inp | op_cma | op_cir | op_cil;
        inr   = op_inc;
        clr   = op_cla;
        e_clr = op_cle;
        e_cpl = op_cme;

        // fixed order among data selects when more than one is raised
        if (op_and)      sel = SEL_AND;
        else if (op_add) sel = SEL_ADD;
        else if (op_ldr) sel = SEL_DR;
        else if (op_inp) sel = SEL_INP;
        else if (op_cma) sel = SEL_COM;
        else if (op_cir) sel = SEL_SHR;
        else if (op_cil) sel = SEL_SHL;
        else             sel = SEL_AND;
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input  logic [W-1:0]    acc,
    input  logic            ext,
    input  logic [W-1:0]    dr,
    input  logic [IN_W-1:0] inp,
    input  data_sel_e       sel,
    output logic [W-1:0]    res,
    output logic            res_ext,
    output logic            res_ext_we
);

    logic [W:0] sum;

    always_comb begin
        sum        = {1'b0, acc} + {1'b0, dr};
        res        = acc;
        res_ext    = ext;
        res_ext_we = 1'b0;
        case (sel)
            SEL_AND: res = acc & dr;
            SEL_ADD: begin
                res        = sum[W-1:0];
                res_ext    = sum[W];
                res_ext_we = 1'b1;
            end
            SEL_DR:  res = dr;
            SEL_INP: res = {acc[W-1:IN_W], inp};
            SEL_COM: res = ~acc;
            SEL_SHR: begin
                res        = {ext, acc[W-1:1]};
                res_ext    = acc[0];
                res_ext_we = 1'b1;
            end
            SEL_SHL: begin
                res        = {acc[W-2:0], ext};
                res_ext    = acc[W-1];
                res_ext_we = 1'b1;
            end
            default: res = acc;
        endcase
    end

endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic         ext,
    output logic         zero,
    output logic         neg,
    output logic         ezero
);

    always_comb begin
        zero  = ~|acc;
        neg   = acc[W-1];
        ezero = ~ext;
    end

endmodule

// File: rtl/acc_ext_unit.sv
module acc_ext_unit
    import acc_pkg::*;
#(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_and,
    input  logic            op_add,
    input  logic            op_ldr,
    input  logic            op_inp,
    input  logic            op_cma,
    input  logic            op_cir,
    input  logic            op_cil,
    input  logic            op_inc,
    input  logic            op_cla,
    input  logic            op_cle,
    input  logic            op_cme,
    input  logic [W-1:0]    dr_i,
    input  logic [IN_W-1:0] inp_i,
    output logic [W-1:0]    acc_o,
    output logic            ext_o,
    output logic            acc_zero_o,
    output logic            acc_neg_o,
    output logic            ext_zero_o,
    output logic            ld_o,
    output logic            inr_o,
    output logic            clr_o
);

    typedef struct packed {
        logic [W-1:0] acc;
        logic         ext;
    } state_t;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    state_t    st_d, st_q;
    logic      ld, inr, clr, e_clr, e_cpl;
    data_sel_e sel;
    logic [W-1:0] alu_res;
    logic         alu_ext, alu_ext_we;
    logic         ext_by_alu;

    acc_gate u_gate (
        .op_and (op_and), .op_add (op_add), .op_ldr (op_ldr),
        .op_inp (op_inp), .op_cma (op_cma), .op_cir (op_cir),
        .op_cil (op_cil), .op_inc (op_inc), .op_cla (op_cla),
        .op_cle (op_cle), .op_cme (op_cme),
        .ld (ld), .inr (inr), .clr (clr), .sel (sel),
        .e_clr (e_clr), .e_cpl (e_cpl)
    );

    acc_alu #(.W(W), .IN_W(IN_W)) u_alu (
        .acc        (st_q.acc),
        .ext        (st_q.ext),
        .dr         (dr_i),
        .inp        (inp_i),
        .sel        (sel),
        .res        (alu_res),
        .res_ext    (alu_ext),
        .res_ext_we (alu_ext_we)
    );

    acc_flags #(.W(W)) u_flags (
        .acc   (st_q.acc),
        .ext   (st_q.ext),
        .zero  (acc_zero_o),
        .neg   (acc_neg_o),
        .ezero (ext_zero_o)
    );

    always_comb begin
        st_d       = st_q;
        ext_by_alu = ld & ~inr & ~clr & alu_ext_we;
        if (clr)      st_d.acc = '0;
        else if (inr) st_d.acc = st_q.acc + ONE;
        else if (ld)  st_d.acc = alu_res;

        if (ext_by_alu)  st_d.ext = alu_ext;
        else if (e_clr)  st_d.ext = 1'b0;
        else if (e_cpl)  st_d.ext = ~st_q.ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;
    assign ext_o = st_q.ext;
    assign ld_o  = ld;
    assign inr_o = inr;
    assign clr_o = clr;

endmodule

// File: rtl/acc_ext_chk.sv
module acc_ext_chk #(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_and,
    input logic            op_add,
    input logic            op_ldr,
    input logic            op_inp,
    input logic            op_cma,
    input logic            op_cir,
    input logic            op_cil,
    input logic            op_inc,
    input logic            op_cla,
    input logic            op_cle,
    input logic            op_cme,
    input logic [W-1:0]    dr_i,
    input logic [IN_W-1:0] inp_i,
    input logic [W-1:0]    acc_o,
    input logic            ext_o,
    input logic            acc_zero_o,
    input logic            acc_neg_o,
    input logic            ext_zero_o,
    input logic            ld_o,
    input logic            inr_o,
    input logic            clr_o
);

    logic [10:0] ops;
    assign ops = {op_and, op_add, op_ldr, op_inp, op_cma, op_cir,
                  op_cil, op_inc, op_cla, op_cle, op_cme};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0 && !ext_o));

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_add && $countones(ops) == 1) |=>
            ({ext_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(dr_i)})));

    // R4
    load_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_o && !inr_o && !clr_o && op_ldr && $countones(ops) == 1) |=>
            (acc_o == $past(dr_i) && ext_o == $past(ext_o)));

    // R5
    byte_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_inp && $countones(ops) == 1) |=>
            (acc_o[IN_W-1:0] == $past(inp_i) && $stable(acc_o[W-1:IN_W]) && $stable(ext_o)));

    // R7
    rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cir && $countones(ops) == 1) |=>
            (acc_o == {$past(ext_o), $past(acc_o[W-1:1])} && ext_o == $past(acc_o[0])));

    // R8
    rot_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_cil && $countones(ops) == 1) |=>
            (acc_o == {$past(acc_o[W-2:0]), $past(ext_o)} && ext_o == $past(acc_o[W-1])));

    // R9
    incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inr_o && !clr_o && $countones(ops) == 1) |=>
            (acc_o == $past(acc_o) + {{(W-1){1'b0}}, 1'b1} && $stable(ext_o)));

    // R10
    clear_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> (acc_o == '0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ops == '0) |=> ($stable(acc_o) && $stable(ext_o)));

    // R12
    status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_zero_o == (acc_o == '0)) && (acc_neg_o == acc_o[W-1]) && (ext_zero_o == !ext_o));

endmodule

bind acc_ext_unit acc_ext_chk #(.W(W), .IN_W(IN_W)) u_chk (.*);

// File: tb/tb_acc_ext_unit.sv
module tb_acc_ext_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    localparam int B_CLE = 0, B_CME = 1, B_AND = 2, B_ADD = 3, B_LDR = 4,
                   B_INP = 5, B_CMA = 6, B_CIR = 7, B_CIL = 8, B_INC = 9,
                   B_CLA = 10;

    localparam logic [10:0] O_CLE = 11'd1 << B_CLE;
    localparam logic [10:0] O_CME = 11'd1 << B_CME;
    localparam logic [10:0] O_AND = 11'd1 << B_AND;
    localparam logic [10:0] O_ADD = 11'd1 << B_ADD;
    localparam logic [10:0] O_LDR = 11'd1 << B_LDR;
    localparam logic [10:0] O_INP = 11'd1 << B_INP;
    localparam logic [10:0] O_CMA = 11'd1 << B_CMA;
    localparam logic [10:0] O_CIR = 11'd1 << B_CIR;
    localparam logic [10:0] O_CIL = 11'd1 << B_CIL;
    localparam logic [10:0] O_INC = 11'd1 << B_INC;
    localparam logic [10:0] O_CLA = 11'd1 << B_CLA;

    // {ops, dr, inp, expected acc, expected ext}
    localparam logic [51:0] VECS [0:NV-1] = '{
        {O_LDR,  16'h1234, 8'h00, 16'h1234, 1'b0},
        {O_AND,  16'h0FF0, 8'h00, 16'h0230, 1'b0},
        {O_ADD,  16'hFFD0, 8'h00, 16'h0200, 1'b1},
        {O_ADD,  16'h0001, 8'h00, 16'h0201, 1'b0},
        {O_CMA,  16'h0000, 8'h00, 16'hFDFE, 1'b0},
        {O_CME,  16'h0000, 8'h00, 16'hFDFE, 1'b1},
        {O_CIR,  16'h0000, 8'h00, 16'hFEFF, 1'b0},
        {O_CIL,  16'h0000, 8'h00, 16'hFDFE, 1'b1},
        {O_INP,  16'hFFFF, 8'hA5, 16'hFDA5, 1'b1},
        {O_INC,  16'h0000, 8'h00, 16'hFDA6, 1'b1},
        {O_CLE,  16'h0000, 8'h00, 16'hFDA6, 1'b0},
        {O_LDR,  16'hFFFF, 8'h00, 16'hFFFF, 1'b0},
        {O_INC,  16'h0000, 8'h00, 16'h0000, 1'b0},
        {O_LDR,  16'h8001, 8'h00, 16'h8001, 1'b0},
        {O_CIL,  16'h0000, 8'h00, 16'h0002, 1'b1},
        {O_CIR,  16'h0000, 8'h00, 16'h8001, 1'b0},
        {O_CLA,  16'h0000, 8'h00, 16'h0000, 1'b0},
        {11'd0,  16'hFFFF, 8'hFF, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ops = '0;
    logic [15:0] dr = '0;
    logic [7:0]  inp = '0;
    logic [15:0] acc;
    logic        ext, acc_zero, acc_neg, ext_zero, ld, inr, clr;
    int          errors = 0;
    int          checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_ext_unit dut (
        .clk (clk), .rst_n (rst_n),
        .op_and (ops[B_AND]), .op_add (ops[B_ADD]), .op_ldr (ops[B_LDR]),
        .op_inp (ops[B_INP]), .op_cma (ops[B_CMA]), .op_cir (ops[B_CIR]),
        .op_cil (ops[B_CIL]), .op_inc (ops[B_INC]), .op_cla (ops[B_CLA]),
        .op_cle (ops[B_CLE]), .op_cme (ops[B_CME]),
        .dr_i (dr), .inp_i (inp),
        .acc_o (acc), .ext_o (ext),
        .acc_zero_o (acc_zero), .acc_neg_o (acc_neg), .ext_zero_o (ext_zero),
        .ld_o (ld), .inr_o (inr), .clr_o (clr)
    );

    function automatic string tag_of(input logic [10:0] o);
        case (o)
            O_AND:   return "R2";
            O_ADD:   return "R3";
            O_LDR:   return "R4";
            O_INP:   return "R5";
            O_CMA:   return "R6";
            O_CIR:   return "R7";
            O_CIL:   return "R8";
            O_INC:   return "R9";
            O_CLA, O_CLE, O_CME: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [10:0] o, input logic [15:0] d, input logic [7:0] b);
        @(negedge clk);
        ops = o;
        dr  = d;
        inp = b;
        @(posedge clk);
        #1;
    endtask

    task automatic check_state(input string tag, input logic [15:0] ea, input logic ee);
        check(tag, {ext, acc}, {ee, ea});
        check("R12", {14'd0, acc_zero, acc_neg, ext_zero}, {14'd0, ea == 16'h0, ea[15], !ee});
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R1 reset state
        #(CLK_PERIOD * 2 + 1);
        check_state("R1", 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][51:41], VECS[i][40:25], VECS[i][24:17]);
            check_state(tag_of(VECS[i][51:41]), VECS[i][16:1], VECS[i][0]);
        end

        // R13 gating outputs follow the strobes combinationally
        @(negedge clk);
        ops = O_AND; #1;
        check("R13", {14'd0, ld, inr, clr}, 17'b100);
        ops = O_INC; #1;
        check("R13", {14'd0, ld, inr, clr}, 17'b010);
        ops = O_CLA; #1;
        check("R13", {14'd0, ld, inr, clr}, 17'b001);
        ops = O_CIL | O_INC; #1;
        check("R13", {14'd0, ld, inr, clr}, 17'b110);

        // R13 priority: increment beats load, clear beats both
        step(O_LDR, 16'h00F0, 8'h00);
        check_state("R4", 16'h00F0, 1'b0);
        step(O_INC | O_LDR, 16'h1234, 8'h00);
        check_state("R13", 16'h00F1, 1'b0);
        step(O_CLA | O_INC | O_LDR, 16'h1234, 8'h00);
        check_state("R13", 16'h0000, 1'b0);

        // R3 carry out with a zero sum
        step(O_LDR, 16'h8000, 8'h00);
        step(O_ADD, 16'h8000, 8'h00);
        check_state("R3", 16'h0000, 1'b1);

        // R10 extend ops do not touch the accumulator
        step(O_LDR, 16'h5A5A, 8'h00);
        step(O_CME, 16'h0000, 8'h00);
        check_state("R10", 16'h5A5A, 1'b0);
        step(O_CME, 16'h0000, 8'h00);
        check_state("R10", 16'h5A5A, 1'b1);

        // R1 reset in mid-run
        @(negedge clk);
        ops = '0;
        rst_n = 1'b0;
        #1;
        check_state("R1", 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(11'd0, 16'hFFFF, 8'hFF);
        check_state("R11", 16'h0000, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule